// File: doc/BRIEF.md
# SPI Command Sequencer

This block executes a stream of 16-bit serial-bus commands arriving over a valid/ready handshake. It takes one command at a time. Each command is decoded into one of four actions:

- driving a new chip-select vector, with a guard interval on each side of the change;
- writing one of the small configuration registers;
- emitting a progress token on an output stream;
- pausing for a prescaler-scaled sleep interval.

Transfer commands are not serialised here. Their read flag, write flag and word count go to a separate word-shifter over a start/done pair. The sequencer then stays busy until that shifter reports completion.

The configuration registers hold three values: the clock-mode bits, the prescaler divisor and the word length. They are driven out continuously for use by the shifter. The divisor also scales the guard intervals and the sleep intervals inside this block. A controller upstream typically issues chip-select, configuration, transfer and token commands in sequence. It watches the token stream to learn when a transaction has drained.

Top module: `spi_cmd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs_n` is 8'hFF, `cfg_mode` and `cfg_div` are 0, `cfg_len` equals DATA_WIDTH, `cmd_ready` is 1, and `sync_valid` and `xfer_start` are 0.
- R2: A command is classified by bits 13:12: 00 is a transfer, 01 is a chip-select, 10 is a configuration write, 11 is the token/sleep group. Within group 11, bits 9:8 = 00 selects a token and 01 selects a sleep.
- R3: For a chip-select command, take t = bits 9:8 and D = t*(cfg_div+1). `cs_n` changes to bits 7:0 exactly D+1 clock edges after the accepting edge. `cmd_ready` returns high exactly 2D+2 edges after the accepting edge, and `cs_n` changes at no other time.
- R4: For a sleep command, `cmd_ready` stays low for exactly (t+1)*(cfg_div+1)*2 cycles after acceptance, where t = bits 7:0.
- R5: A configuration write takes its address from bits 9:8 and its value from bits 7:0. The written value is visible on the outputs in the cycle after acceptance, and `cmd_ready` stays high. Address 0 writes `cfg_mode`, which keeps only bit 0 (clock phase), bit 1 (clock polarity) and bit 2 (three-wire), with bits 7:3 always reading 0. Address 1 writes `cfg_div`. Address 2 writes `cfg_len`. `cfg_div` changes only through such a write.
- R6: A configuration write to address 3 leaves `cfg_mode`, `cfg_div` and `cfg_len` unchanged.
- R7: A token command raises `sync_valid` in the cycle after acceptance, with `sync_id` equal to bits 7:0. Both stay stable until a cycle in which `sync_ready` is high, after which `sync_valid` falls and the sequencer is ready again.
- R8: A transfer command produces a single-cycle `xfer_start` pulse in the cycle after acceptance. In that pulse, `xfer_rd` = bit 9, `xfer_wr` = bit 8 and `xfer_words` = bits 7:0 (which encode words minus one). `cmd_ready` returns high on the edge after `xfer_done` is seen high.
- R9: `cmd_ready` is low in every cycle in which an accepted command is still executing.
- R10: A command with any of bits 15, 14, 11 or 10 set, or a group-11 command with bits 9:8 equal to 10 or 11, is discarded with no visible effect, and `cmd_ready` stays high.
- R11: A pulse on `xfer_done` while no transfer is pending has no effect on `cmd_ready`, `xfer_start` or any later command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Sequencer idle and accepting a command |
| cmd_data | input | 16 | Command word |
| cs_n | output | 8 | Chip-select vector |
| sync_valid | output | 1 | Token available |
| sync_ready | input | 1 | Token consumer ready |
| sync_id | output | 8 | Token value |
| xfer_start | output | 1 | One-cycle transfer launch |
| xfer_rd | output | 1 | Transfer samples input data |
| xfer_wr | output | 1 | Transfer drives output data |
| xfer_words | output | 8 | Transfer word count minus one |
| xfer_done | input | 1 | Shifter finished the transfer |
| cfg_mode | output | 8 | Clock-mode register (bit 0 phase, bit 1 polarity, bit 2 three-wire) |
| cfg_div | output | 8 | Prescaler divisor |
| cfg_len | output | 8 | Word length in bits |

## Verification
A wrong execution state shows up at the ports as a `cmd_ready` edge that comes early or late. It can also show up as a `cs_n` change placed off its D+1 position. Because the guard and sleep intervals are counted exactly, a corrupted counter appears within one interval as a cycle-count mismatch. A bad decode appears in the very next cycle as a missing or extra pulse on `xfer_start` or `sync_valid`, or as an unexpected change of a configuration output. A token whose value was overwritten while stalled appears when that token is finally consumed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int REG_W     = 8;
    localparam int CS_W      = 8;
    localparam int MODE_BITS = 3;
    localparam int CNT_W     = 2 * REG_W + 2;

    typedef enum logic [1:0] {
        OP_XFER = 2'b00,
        OP_CS   = 2'b01,
        OP_CFG  = 2'b10,
        OP_MISC = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RA_MODE = 2'd0,
        RA_DIV  = 2'd1,
        RA_LEN  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_PRE,
        ST_CS_POST,
        ST_SLEEP,
        ST_SYNC,
        ST_XFER
    } state_e;

    typedef struct packed {
        logic [3:0]       rsv;
        op_e              op;
        logic [1:0]       sub;
        logic [REG_W-1:0] arg;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [15:0] w);
        cmd_t c;
        c.rsv = {w[15:14], w[11:10]};
        c.op  = op_e'(w[13:12]);
        c.sub = w[9:8];
        c.arg = w[7:0];
        return c;
    endfunction

    // guard interval around a chip-select change
    function automatic logic [CNT_W-1:0] cs_guard(input logic [1:0] t, input logic [REG_W-1:0] div);
        return CNT_W'(t) * (CNT_W'(div) + CNT_W'(1));
    endfunction

    // last count value of a sleep (total length minus one)
    function automatic logic [CNT_W-1:0] sleep_last(input logic [REG_W-1:0] t, input logic [REG_W-1:0] div);
        return (((CNT_W'(t) + CNT_W'(1)) * (CNT_W'(div) + CNT_W'(1))) << 1) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/spi_cmd_timer.sv
module spi_cmd_timer
    import spi_cmd_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DATA_WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_addr_e        addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mode_o,
    output logic [REG_W-1:0] div_o,
    output logic [REG_W-1:0] len_o
);

    localparam logic [REG_W-1:0] LEN_RST = REG_W'(DATA_WIDTH);

    logic [MODE_BITS-1:0] mode_q;
    logic [REG_W-1:0]     div_q;
    logic [REG_W-1:0]     len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            div_q  <= '0;
            len_q  <= LEN_RST;
        end else if (we) begin
            unique case (addr)
                RA_MODE: mode_q <= wdata[MODE_BITS-1:0];
                RA_DIV:  div_q  <= wdata;
                RA_LEN:  len_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign mode_o = {{(REG_W-MODE_BITS){1'b0}}, mode_q};
    assign div_o  = div_q;
    assign len_o  = len_q;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DATA_WIDTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [15:0] cmd_data,
    output logic [7:0]  cs_n,
    output logic        sync_valid,
    input  logic        sync_ready,
    output logic [7:0]  sync_id,
    output logic        xfer_start,
    output logic        xfer_rd,
    output logic        xfer_wr,
    output logic [7:0]  xfer_words,
    input  logic        xfer_done,
    output logic [7:0]  cfg_mode,
    output logic [7:0]  cfg_div,
    output logic [7:0]  cfg_len
);

    state_e           state_q;
    cmd_t             cmd;
    logic             take;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic [CNT_W-1:0] guard_q;
    logic [CS_W-1:0]  cs_q;
    logic [CS_W-1:0]  cs_pend_q;
    logic             sv_q;
    logic [REG_W-1:0] sid_q;
    logic             xs_q;
    logic             xrd_q;
    logic             xwr_q;
    logic [REG_W-1:0] xwords_q;

    assign cmd       = unpack_cmd(cmd_data);
    assign cmd_ready = (state_q == ST_IDLE);
    assign take      = cmd_valid && cmd_ready && (cmd.rsv == '0);

    spi_cmd_regs #(.DATA_WIDTH(DATA_WIDTH)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (take && cmd.op == OP_CFG),
        .addr   (reg_addr_e'(cmd.sub)),
        .wdata  (cmd.arg),
        .mode_o (cfg_mode),
        .div_o  (cfg_div),
        .len_o  (cfg_len)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (take && cmd.op == OP_CS) begin
            tmr_load = 1'b1;
            tmr_val  = cs_guard(cmd.sub, cfg_div);
        end else if (take && cmd.op == OP_MISC && cmd.sub == 2'b01) begin
            tmr_load = 1'b1;
            tmr_val  = sleep_last(cmd.arg, cfg_div);
        end else if (state_q == ST_CS_PRE && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = guard_q;
        end
    end

    spi_cmd_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            guard_q   <= '0;
            cs_q      <= '1;
            cs_pend_q <= '1;
            sv_q      <= 1'b0;
            sid_q     <= '0;
            xs_q      <= 1'b0;
            xrd_q     <= 1'b0;
            xwr_q     <= 1'b0;
            xwords_q  <= '0;
        end else begin
            xs_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        unique case (cmd.op)
                            OP_XFER: begin
                                xs_q     <= 1'b1;
                                xrd_q    <= cmd.sub[1];
                                xwr_q    <= cmd.sub[0];
                                xwords_q <= cmd.arg;
                                state_q  <= ST_XFER;
                            end
                            OP_CS: begin
                                cs_pend_q <= cmd.arg;
                                guard_q   <= cs_guard(cmd.sub, cfg_div);
                                state_q   <= ST_CS_PRE;
                            end
                            OP_MISC: begin
                                if (cmd.sub == 2'b00) begin
                                    sv_q    <= 1'b1;
                                    sid_q   <= cmd.arg;
                                    state_q <= ST_SYNC;
                                end else if (cmd.sub == 2'b01) begin
                                    state_q <= ST_SLEEP;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CS_PRE: begin
                    if (tmr_zero) begin
                        cs_q    <= cs_pend_q;
                        state_q <= ST_CS_POST;
                    end
                end
                ST_CS_POST, ST_SLEEP: begin
                    if (tmr_zero) state_q <= ST_IDLE;
                end
                ST_SYNC: begin
                    if (sync_ready) begin
                        sv_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    if (xfer_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n       = cs_q;
    assign sync_valid = sv_q;
    assign sync_id    = sid_q;
    assign xfer_start = xs_q;
    assign xfer_rd    = xrd_q;
    assign xfer_wr    = xwr_q;
    assign xfer_words = xwords_q;

endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [15:0] cmd_data,
    input logic [7:0]  cs_n,
    input logic        sync_valid,
    input logic        sync_ready,
    input logic [7:0]  sync_id,
    input logic        xfer_start,
    input logic [7:0]  cfg_div
);

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sync_valid && !sync_ready) |=> (sync_valid && $stable(sync_id))); // R7

    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start); // R8

    AST_XFER_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(cmd_valid && cmd_ready && cmd_data[13:12] == 2'b00)); // R8

    AST_BUSY_WHILE_TOKEN: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> !cmd_ready); // R9

    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> !$past(cmd_ready)); // R3

    AST_DIV_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_div) |-> $past(cmd_valid && cmd_ready && cmd_data[13:12] == 2'b10
                                    && cmd_data[9:8] == 2'b01)); // R5

endmodule

bind spi_cmd_seq spi_cmd_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_data   (cmd_data),
    .cs_n       (cs_n),
    .sync_valid (sync_valid),
    .sync_ready (sync_ready),
    .sync_id    (sync_id),
    .xfer_start (xfer_start),
    .cfg_div    (cfg_div)
);

// File: tb/test_spi_cmd_seq.sv
module test_spi_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic [7:0]  cs_n;
    logic        sync_valid;
    logic        sync_ready = 1'b0;
    logic [7:0]  sync_id;
    logic        xfer_start;
    logic        xfer_rd;
    logic        xfer_wr;
    logic [7:0]  xfer_words;
    logic        xfer_done = 1'b0;
    logic [7:0]  cfg_mode;
    logic [7:0]  cfg_div;
    logic [7:0]  cfg_len;

    spi_cmd_seq #(.DATA_WIDTH(DW)) i_spi_cmd_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cs_n(cs_n), .sync_valid(sync_valid),
        .sync_ready(sync_ready), .sync_id(sync_id), .xfer_start(xfer_start),
        .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .xfer_words(xfer_words),
        .xfer_done(xfer_done), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
        .cfg_len(cfg_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit stray_req = 1'b0;
    int lat = 0;

    logic [7:0] exp_sync[$];
    logic [9:0] exp_xfer[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares produced tokens and transfer launches
    logic       prev_sv = 1'b0;
    logic [7:0] prev_id = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sv && !sync_valid) begin
                if (exp_sync.size() == 0) chk("R7 unexpected token", 1, 0);
                else chk("R7 token id", int'(prev_id), int'(exp_sync.pop_front()));
            end
            if (xfer_start) begin
                if (exp_xfer.size() == 0) chk("R8 unexpected xfer_start", 1, 0);
                else chk("R8 transfer fields", int'({xfer_rd, xfer_wr, xfer_words}),
                         int'(exp_xfer.pop_front()));
            end
        end
        prev_sv = sync_valid;
        prev_id = sync_id;
    end

    // word-shifter model: completes 3 cycles after seeing a launch
    always @(negedge clk) begin
        xfer_done = stray_req;
        if (xfer_start) lat = 3;
        else if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) xfer_done = 1'b1;
        end
    end

    task automatic send(input logic [15:0] w, output int acc);
        cmd_data  = w;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        acc = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_cs(input logic [7:0] v, input int acc, output int d);
        int n = 0;
        while (cs_n !== v && n < 2000) begin @(negedge clk); n++; end
        d = cyc - acc;
    endtask

    task automatic wait_ready(input int acc, output int d);
        int n = 0;
        while (cmd_ready !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        d = cyc - acc;
    endtask

    initial begin
        int acc;
        int d;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", cs_n, 8'hFF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n", cs_n, 8'hFF);
        chk("R1 cfg_mode", cfg_mode, 0);
        chk("R1 cfg_div", cfg_div, 0);
        chk("R1 cfg_len", cfg_len, DW);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 sync_valid", sync_valid, 0);
        chk("R1 xfer_start", xfer_start, 0);

        // R6: address 3 discarded
        send(16'h2355, acc);
        chk("R6 mode kept", cfg_mode, 0);
        chk("R6 div kept", cfg_div, 0);
        chk("R6 len kept", cfg_len, DW);

        // R5: configuration writes
        send(16'h20FF, acc);
        chk("R5 mode reserved bits zero", cfg_mode, 8'h07);
        chk("R5 ready stays high", cmd_ready, 1);
        send(16'h2002, acc);
        chk("R5 mode polarity only", cfg_mode, 8'h02);
        send(16'h220C, acc);
        chk("R5 len write", cfg_len, 12);
        send(16'h2102, acc);
        chk("R5 div write", cfg_div, 2);

        // R3: chip-select with guard t=3, div=2 -> D=9
        send(16'h13A5, acc);
        chk("R3 cs unchanged at accept", cs_n, 8'hFF);
        chk("R9 busy during cs", cmd_ready, 0);
        wait_cs(8'hA5, acc, d);
        chk("R3 cs change cycle", d, 10);
        wait_ready(acc, d);
        chk("R3 cs ready cycle", d, 20);
        // R2: chip-select group with t=0
        send(16'h103C, acc);
        wait_cs(8'h3C, acc, d);
        chk("R2 R3 cs t0 change cycle", d, 1);
        wait_ready(acc, d);
        chk("R3 cs t0 ready cycle", d, 2);

        // R4: sleep t=2, div=2 -> 18 cycles
        send(16'h3102, acc);
        wait_ready(acc, d);
        chk("R4 sleep length div2", d, 18);
        send(16'h2100, acc);
        send(16'h3100, acc);
        wait_ready(acc, d);
        chk("R4 sleep length div0", d, 2);

        // R7: token with stalled consumer
        exp_sync.push_back(8'h5A);
        send(16'h305A, acc);
        chk("R7 valid raised", sync_valid, 1);
        chk("R7 id", sync_id, 8'h5A);
        chk("R9 busy during token", cmd_ready, 0);
        repeat (4) @(negedge clk);
        chk("R7 valid held", sync_valid, 1);
        chk("R7 id held", sync_id, 8'h5A);
        chk("R9 still busy", cmd_ready, 0);
        sync_ready = 1'b1;
        @(negedge clk);
        sync_ready = 1'b0;
        chk("R7 valid dropped", sync_valid, 0);
        chk("R7 ready after token", cmd_ready, 1);
        // token with consumer already ready
        sync_ready = 1'b1;
        exp_sync.push_back(8'hC3);
        send(16'h30C3, acc);
        chk("R2 token group decode", sync_valid, 1);
        @(negedge clk);
        sync_ready = 1'b0;
        chk("R7 immediate handshake", cmd_ready, 1);

        // R11: stray done while idle
        stray_req = 1'b1;
        repeat (2) @(negedge clk);
        stray_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 ready unaffected", cmd_ready, 1);
        chk("R11 no launch", xfer_start, 0);

        // R8: transfers
        exp_xfer.push_back(10'h305);
        send(16'h0305, acc);
        chk("R2 transfer launch", xfer_start, 1);
        chk("R9 busy during transfer", cmd_ready, 0);
        wait_ready(acc, d);
        chk("R8 ready after done", d, 4);
        exp_xfer.push_back(10'h100);
        send(16'h0100, acc);
        wait_ready(acc, d);
        chk("R8 write-only ready", d, 4);
        exp_xfer.push_back(10'h2FF);
        send(16'h02FF, acc);
        wait_ready(acc, d);
        chk("R8 read-only ready", d, 4);

        // R10: discarded commands
        send(16'h3255, acc);
        chk("R10 reserved sub ready", cmd_ready, 1);
        chk("R10 reserved sub no token", sync_valid, 0);
        send(16'h4105, acc);
        chk("R10 reserved bit no launch", xfer_start, 0);
        chk("R10 reserved bit ready", cmd_ready, 1);
        send(16'h0D07, acc);
        chk("R10 reserved bit cs kept", cs_n, 8'h3C);
        chk("R10 reserved bit ready2", cmd_ready, 1);

        repeat (3) @(negedge clk);
        chk("R7 all tokens seen", exp_sync.size(), 0);
        chk("R8 all transfers seen", exp_xfer.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule